// File: doc/BRIEF.md
# Packet Receiver with Interrupt-Qualified Cross-Clock Payload Handoff

This block takes a four-frame packet arriving one byte at a time on a baud-rate clock and hands its two payload bytes to an asynchronous system-clock domain. The payload bytes themselves are never synchronized. The baud side marks a completed packet with a pending flag. That flag is the only thing that crosses into the system domain: it passes through a two-flop synchronizer and appears as a level interrupt. The system raises an acknowledge level, which travels back through a two-flop synchronizer, and the baud side then clears the pending flag. While the handshake is open, the payload output registers are frozen. This is what makes it safe for system-clock logic to read them directly.

The baud-side sequencer has four states. `RX_HUNT` waits for a start frame. `RX_FIRST` and `RX_SECOND` capture the two payload bytes into staging registers. `RX_CLOSE` checks the closing frame. The transitions are:

- `RX_HUNT -> RX_FIRST` on a valid start code.
- `RX_FIRST -> RX_SECOND` on any valid frame.
- `RX_SECOND -> RX_CLOSE` on any valid frame.
- `RX_CLOSE -> RX_HUNT` on any valid frame. The packet is accepted only if that frame is the end code.

An accepted packet is published to the output registers unless a handoff is still open. In that case the packet is dropped and a sticky overrun flag is set. Each clock domain has its own asynchronous active-low reset.

Top module: `pkt_handoff_rx`

## Requirements
- R1: After reset, `sys_irq`, `rx_overrun`, `pay_first` and `pay_second` are all 0.
- R2: The frame sequence 0xA5, P1, P2, 0x5A (each with `frm_valid` high) makes `pay_first`=P1 and `pay_second`=P2 and raises `sys_irq`.
- R3: Cycles with `frm_valid` low are ignored, whatever `frm_data` holds, and may appear between the frames of a packet.
- R4: A non-0xA5 frame while hunting is ignored. A fourth frame other than 0x5A discards the packet: no interrupt, the payload is unchanged, no overrun, and the receiver hunts for 0xA5 again.
- R5: `sys_irq` stays high while `sys_ack` is low. Once `sys_ack` is raised, `sys_irq` falls within three system cycles after the synchronized acknowledge clears the pending flag.
- R6: While the synchronized acknowledge is still high, no new packet is published. A packet completed in that window is dropped and sets `rx_overrun`.
- R7: A packet completed while the previous one is pending is dropped. The payload outputs keep the earlier values and `rx_overrun` is set.
- R8: `rx_overrun` is sticky and clears only on the baud-domain reset.
- R9: `pay_first` and `pay_second` do not change while a packet is pending or the synchronized acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| baud_clk | input | 1 | Frame (baud-rate) clock |
| baud_rst_n | input | 1 | Asynchronous active-low reset, baud domain |
| frm_valid | input | 1 | Frame strobe, one baud cycle per frame |
| frm_data | input | 8 | Frame byte |
| rx_overrun | output | 1 | Sticky dropped-packet flag (baud domain) |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| sys_ack | input | 1 | Acknowledge level, held until `sys_irq` falls |
| sys_irq | output | 1 | Synchronized packet-ready level |
| pay_first | output | 8 | First payload byte (unsynchronized, stable while handed off) |
| pay_second | output | 8 | Second payload byte (unsynchronized, stable while handed off) |

## Verification
The assertions check four properties on every baud cycle:

- The payload registers are frozen whenever a handoff is open.
- The overrun flag never falls.
- A synchronized acknowledge always clears the pending flag.
- A bad closing frame returns the sequencer to hunting without publishing.

Only the directed scenarios can show the end-to-end effects across the clock boundary. These are that a full packet eventually raises the interrupt with the right bytes, that the interrupt holds without an acknowledge and falls after one, that a packet completed in the acknowledge-tail window is lost, and that malformed or strobe-less frames leave everything visible untouched.

// File: rtl/pkt_handoff_pkg.sv
package pkt_handoff_pkg;
    typedef enum logic [1:0] {
        RX_HUNT   = 2'd0,
        RX_FIRST  = 2'd1,
        RX_SECOND = 2'd2,
        RX_CLOSE  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/pkt_sync_bit.sv
module pkt_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pkt_frame_fsm.sv
module pkt_frame_fsm
    import pkt_handoff_pkg::*;
#(
    parameter int               FRAME_W  = 8,
    parameter logic [FRAME_W-1:0] OPEN_CODE  = 8'hA5,
    parameter logic [FRAME_W-1:0] CLOSE_CODE = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    input  logic [FRAME_W-1:0] frm_data,
    input  logic               ack_seen,
    output logic               pend,
    output logic               overrun,
    output logic [FRAME_W-1:0] pay_a,
    output logic [FRAME_W-1:0] pay_b
);
    rx_state_e          state, nxt;
    logic               cap_a, cap_b, close_ok;
    logic [FRAME_W-1:0] stage_a, stage_b;
    logic               busy;

    assign busy = pend | ack_seen;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= nxt;
    end

    // Next state and per-frame strobes
    always_comb begin
        nxt      = state;
        cap_a    = 1'b0;
        cap_b    = 1'b0;
        close_ok = 1'b0;
        unique case (state)
            RX_HUNT: begin
                if (frm_valid && frm_data == OPEN_CODE) nxt = RX_FIRST;
            end
            RX_FIRST: begin
                if (frm_valid) begin
                    cap_a = 1'b1;
                    nxt   = RX_SECOND;
                end
            end
            RX_SECOND: begin
                if (frm_valid) begin
                    cap_b = 1'b1;
                    nxt   = RX_CLOSE;
                end
            end
            RX_CLOSE: begin
                if (frm_valid) begin
                    close_ok = (frm_data == CLOSE_CODE);
                    nxt      = RX_HUNT;
                end
            end
            default: nxt = RX_HUNT;
        endcase
    end

    // Staging registers: only the sequencer writes them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            if (cap_a) stage_a <= frm_data;
            if (cap_b) stage_b <= frm_data;
        end
    end

    // Publish, pending and overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            overrun <= 1'b0;
            pay_a   <= '0;
            pay_b   <= '0;
        end else begin
            if (ack_seen) pend <= 1'b0;
            if (close_ok) begin
                if (busy) begin
                    overrun <= 1'b1;
                end else begin
                    pay_a <= stage_a;
                    pay_b <= stage_b;
                    pend  <= 1'b1;
                end
            end
        end
    end

    // R9: payload frozen while a handoff is open
    a_r9_pay_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pay_a) && $stable(pay_b)));

    // R8: overrun never falls while out of reset
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5: synchronized acknowledge clears pending
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> !pend);

    // R4: a bad closing frame returns to hunting without publishing
    a_r4_bad_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_CLOSE && frm_valid && frm_data != CLOSE_CODE)
        |=> (state == RX_HUNT && !$rose(pend)));
endmodule

// File: rtl/pkt_handoff_rx.sv
module pkt_handoff_rx #(
    parameter int               FRAME_W     = 8,
    parameter logic [FRAME_W-1:0] OPEN_CODE   = 8'hA5,
    parameter logic [FRAME_W-1:0] CLOSE_CODE  = 8'h5A,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               baud_clk,
    input  logic               baud_rst_n,
    input  logic               frm_valid,
    input  logic [FRAME_W-1:0] frm_data,
    output logic               rx_overrun,
    input  logic               sys_clk,
    input  logic               sys_rst_n,
    input  logic               sys_ack,
    output logic               sys_irq,
    output logic [FRAME_W-1:0] pay_first,
    output logic [FRAME_W-1:0] pay_second
);
    logic pend_b;
    logic ack_b;

    pkt_frame_fsm #(
        .FRAME_W   (FRAME_W),
        .OPEN_CODE (OPEN_CODE),
        .CLOSE_CODE(CLOSE_CODE)
    ) u_fsm (
        .clk      (baud_clk),
        .rst_n    (baud_rst_n),
        .frm_valid(frm_valid),
        .frm_data (frm_data),
        .ack_seen (ack_b),
        .pend     (pend_b),
        .overrun  (rx_overrun),
        .pay_a    (pay_first),
        .pay_b    (pay_second)
    );

    // Pending flag into the system domain
    pkt_sync_bit #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk  (sys_clk),
        .rst_n(sys_rst_n),
        .d    (pend_b),
        .q    (sys_irq)
    );

    // Acknowledge back into the baud domain
    pkt_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk  (baud_clk),
        .rst_n(baud_rst_n),
        .d    (sys_ack),
        .q    (ack_b)
    );
endmodule

// File: tb/pkt_handoff_rx_test.sv
`timescale 1ns/1ps
module pkt_handoff_rx_test;
    logic       baud_clk = 1'b0, sys_clk = 1'b0;
    logic       baud_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic       frm_valid = 1'b0, sys_ack = 1'b0;
    logic [7:0] frm_data = 8'h00;
    logic       rx_overrun, sys_irq;
    logic [7:0] pay_first, pay_second;
    int         errors = 0, checks = 0;
    bit         finished = 1'b0;

    always #5  sys_clk  = ~sys_clk;   // 100 MHz
    always #18 baud_clk = ~baud_clk;  // unrelated baud clock

    pkt_handoff_rx uut (
        .baud_clk(baud_clk), .baud_rst_n(baud_rst_n), .frm_valid(frm_valid),
        .frm_data(frm_data), .rx_overrun(rx_overrun), .sys_clk(sys_clk),
        .sys_rst_n(sys_rst_n), .sys_ack(sys_ack), .sys_irq(sys_irq),
        .pay_first(pay_first), .pay_second(pay_second)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_baud(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge baud_clk);
            frm_valid = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge baud_clk);
        frm_valid = 1'b1;
        frm_data  = d;
        @(negedge baud_clk);
        frm_valid = 1'b0;
        frm_data  = 8'hA5;  // noise on data with strobe low
    endtask

    task automatic packet(input logic [7:0] s, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] e);
        send(s); send(a); send(b); send(e);
        idle_baud(4);
        @(negedge sys_clk);
    endtask

    // Raise ack, wait for irq to fall, then drop ack and let it settle
    task automatic handshake(input string req);
        int n = 0;
        @(negedge sys_clk);
        sys_ack = 1'b1;
        while (sys_irq && n < 40) begin
            @(negedge sys_clk);
            n++;
        end
        chk(req, "irq fell after ack within bound", int'(n < 40), 1);
        sys_ack = 1'b0;
        idle_baud(5);
        @(negedge sys_clk);
    endtask

    task automatic t_reset;
        chk("R1", "irq", sys_irq, 0);
        chk("R1", "overrun", rx_overrun, 0);
        chk("R1", "pay_first", pay_first, 0);
        chk("R1", "pay_second", pay_second, 0);
    endtask

    task automatic t_basic;
        packet(8'hA5, 8'h12, 8'h34, 8'h5A);
        chk("R2", "irq", sys_irq, 1);
        chk("R2", "pay_first", pay_first, 8'h12);
        chk("R2", "pay_second", pay_second, 8'h34);
        repeat (60) @(negedge sys_clk);
        chk("R5", "irq held without ack", sys_irq, 1);
        handshake("R5");
        chk("R5", "irq low after handshake", sys_irq, 0);
        chk("R9", "payload kept after handshake", pay_first, 8'h12);
    endtask

    task automatic t_gaps;
        send(8'hA5); idle_baud(3);
        send(8'hC3); idle_baud(2);
        send(8'h3C); idle_baud(5);
        send(8'h5A); idle_baud(4);
        @(negedge sys_clk);
        chk("R3", "irq with gaps", sys_irq, 1);
        chk("R3", "pay_first with gaps", pay_first, 8'hC3);
        chk("R3", "pay_second with gaps", pay_second, 8'h3C);
        handshake("R3");
    endtask

    task automatic t_bad_frames;
        packet(8'hA5, 8'h77, 8'h88, 8'h00);   // wrong closing code
        chk("R4", "irq after bad close", sys_irq, 0);
        chk("R4", "pay_first after bad close", pay_first, 8'hC3);
        chk("R4", "overrun after bad close", rx_overrun, 0);
        packet(8'h5A, 8'h11, 8'h22, 8'h5A);   // no start code
        chk("R4", "irq without start", sys_irq, 0);
        chk("R4", "pay_second without start", pay_second, 8'h3C);
        packet(8'hA5, 8'h9E, 8'hE9, 8'h5A);   // recovers
        chk("R4", "irq after recovery", sys_irq, 1);
        chk("R4", "pay_first after recovery", pay_first, 8'h9E);
        handshake("R4");
    endtask

    task automatic t_overrun_pending;
        packet(8'hA5, 8'h01, 8'h02, 8'h5A);
        chk("R7", "irq first packet", sys_irq, 1);
        chk("R7", "overrun before drop", rx_overrun, 0);
        packet(8'hA5, 8'hF1, 8'hF2, 8'h5A);
        chk("R7", "pay_first kept", pay_first, 8'h01);
        chk("R7", "pay_second kept", pay_second, 8'h02);
        chk("R7", "overrun set", rx_overrun, 1);
        handshake("R7");
        chk("R8", "overrun sticky after handshake", rx_overrun, 1);
    endtask

    task automatic t_ack_tail;
        int n = 0;
        packet(8'hA5, 8'h40, 8'h41, 8'h5A);
        chk("R6", "irq before tail", sys_irq, 1);
        sys_ack = 1'b1;
        while (sys_irq && n < 40) begin
            @(negedge sys_clk);
            n++;
        end
        packet(8'hA5, 8'h50, 8'h51, 8'h5A);   // ack still high
        chk("R6", "pay_first during ack tail", pay_first, 8'h40);
        chk("R6", "irq during ack tail", sys_irq, 0);
        sys_ack = 1'b0;
        idle_baud(5);
        @(negedge sys_clk);
        chk("R6", "irq after ack dropped", sys_irq, 0);
        packet(8'hA5, 8'h60, 8'h61, 8'h5A);
        chk("R6", "accepted after ack dropped", pay_second, 8'h61);
        chk("R8", "overrun still set", rx_overrun, 1);
        handshake("R6");
    endtask

    initial begin
        repeat (100000) @(posedge sys_clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_baud(3);
        baud_rst_n = 1'b1;
        sys_rst_n  = 1'b1;
        idle_baud(2);
        @(negedge sys_clk);
        t_reset;
        t_basic;
        t_gaps;
        t_bad_frames;
        t_overrun_pending;
        t_ack_tail;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule